// File: doc/BRIEF.md
# Fuzzy-Area Border Gate Synchronizer

This block works in the fine stage of a digital frequency lock loop, after coarse lock has been reached. Once per common period it takes the ADC code captured at the zero-crossing feature point. A small frequency offset moves that feature point by a fixed time step every period. The step is much smaller than one ADC LSB, so the captured code stays the same for many periods and then moves to a neighbouring value. Each stretch of identical codes is a fuzzy area.

The block follows these runs and fires a one-cycle gate pulse at the border of a fuzzy area. A border is the moment a new code has lasted for a programmable number of consecutive periods. The gate is tied to the run boundary instead of a preset count, which removes the sub-LSB quantization error. With each gate the block reports two things for the fine correction: how many periods the finished run lasted, and whether the code moved up or down. It raises a lock flag after the code has stayed unchanged for a programmable number of periods. All tracking is active only while the coarse-lock input is high.

Top module: `fuzzy_border_gate`

## Requirements
- R1: The first valid sample after enable (or after reset) becomes the reference run value. It starts a run of length 1 and produces no gate pulse.
- R2: A code that differs from the run value and is seen on persist_k consecutive valid samples is a stable border. After the valid cycle that carries the last of those samples, gate_pulse is high for exactly one clock cycle, and the new code becomes the run value.
- R3: A differing code that lasts fewer than persist_k consecutive valid samples produces no gate pulse and does not change the run value. A candidate whose code changes starts counting again from 1.
- R4: At a gate pulse, run_len holds the number of valid samples equal to the finished run's value. That count includes the persist_k samples that confirmed the run. Samples that did not match are not counted.
- R5: At a gate pulse, dir_up is 1 when the new code is greater than the old run value, compared unsigned. Otherwise dir_up is 0.
- R6: locked becomes 1 once lock_len consecutive valid samples have equalled the run value. After a border, the persist_k confirming samples count toward this total.
- R7: locked is cleared at a stable border. A rejected noise sample leaves locked unchanged, but restarts the count of consecutive matching samples.
- R8: While coarse_locked is low, and during reset, locked, gate_pulse, run_len and dir_up are all 0, and the tracking state is cleared.
- R9: A persist_k value of 0 behaves exactly like a value of 1.
- R10: On clock cycles without sample_valid, the outputs hold their values and gate_pulse stays 0, whatever sample_code carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coarse_locked | input | 1 | Enables tracking. Low clears all state. |
| sample_valid | input | 1 | One strobe per common period |
| sample_code | input | W (16) | ADC code at the feature point |
| persist_k | input | KW (4) | Number of consecutive periods needed to confirm a border |
| lock_len | input | LW (8) | Number of unchanged periods needed to declare lock |
| gate_pulse | output | 1 | One-cycle real gate switch at a border |
| run_len | output | MW (16) | Length of the last completed fuzzy area |
| dir_up | output | 1 | Drift direction of the last border |
| locked | output | 1 | Phase lock flag |

## Verification
A wrong run counter shows up as a wrong run_len at the very next gate pulse. A corrupted run value or candidate value shows up as a missing, extra or early gate on the sample that should confirm the border. An error in the count of matching samples shows up as a lock flag that rises one sample early or late. Every one of these faults is visible at the ports within one common period of the sample that exposes it. The bench therefore compares each gate against an expected queue, and checks the lock flag after every sample.

// File: rtl/fuzzy_border_gate.sv
module fuzzy_border_gate #(
  parameter int W  = 16,
  parameter int KW = 4,
  parameter int LW = 8,
  parameter int MW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          coarse_locked,
  input  logic          sample_valid,
  input  logic [W-1:0]  sample_code,
  input  logic [KW-1:0] persist_k,
  input  logic [LW-1:0] lock_len,
  output logic          gate_pulse,
  output logic [MW-1:0] run_len,
  output logic          dir_up,
  output logic          locked
);
  localparam logic [MW-1:0] RUN_MAX   = '1;
  localparam logic [LW-1:0] STILL_MAX = '1;

  logic          have_ref;
  logic [W-1:0]  cur_code, cand_code;
  logic [KW-1:0] cand_cnt;
  logic [MW-1:0] run_cnt;
  logic [LW-1:0] still_cnt;

  wire [KW-1:0] k_eff     = (persist_k == '0) ? KW'(1) : persist_k;
  wire          match     = sample_code == cur_code;
  wire          cand_hit  = (cand_cnt != '0) && (sample_code == cand_code);
  wire [KW-1:0] cand_next = cand_hit ? cand_cnt + KW'(1) : KW'(1);
  wire          confirm   = have_ref && !match && (cand_next >= k_eff);
  wire [MW-1:0] run_inc   = (run_cnt == RUN_MAX) ? run_cnt : run_cnt + MW'(1);
  wire [LW-1:0] still_inc = (still_cnt == STILL_MAX) ? still_cnt : still_cnt + LW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n || !coarse_locked) begin
      have_ref   <= 1'b0;
      cur_code   <= '0;
      cand_code  <= '0;
      cand_cnt   <= '0;
      run_cnt    <= '0;
      still_cnt  <= '0;
      gate_pulse <= 1'b0;
      run_len    <= '0;
      dir_up     <= 1'b0;
      locked     <= 1'b0;
    end else begin
      gate_pulse <= 1'b0;
      if (sample_valid) begin
        if (!have_ref) begin
          have_ref  <= 1'b1;
          cur_code  <= sample_code;
          cand_cnt  <= '0;
          run_cnt   <= MW'(1);
          still_cnt <= LW'(1);
          if (LW'(1) >= lock_len) locked <= 1'b1;
        end else if (match) begin
          cand_cnt  <= '0;
          run_cnt   <= run_inc;
          still_cnt <= still_inc;
          if (still_inc >= lock_len) locked <= 1'b1;
        end else if (confirm) begin
          gate_pulse <= 1'b1;
          run_len    <= run_cnt;
          dir_up     <= sample_code > cur_code;
          cur_code   <= sample_code;
          cand_cnt   <= '0;
          run_cnt    <= MW'(k_eff);
          still_cnt  <= LW'(k_eff);
          locked     <= 1'b0;
        end else begin
          cand_code <= sample_code;
          cand_cnt  <= cand_next;
          still_cnt <= '0;
        end
      end
    end
  end
endmodule

module fuzzy_border_gate_chk #(
  parameter int MW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          coarse_locked,
  input logic          sample_valid,
  input logic          gate_pulse,
  input logic [MW-1:0] run_len,
  input logic          dir_up,
  input logic          locked
);
  a_r2_gate_single: assert property (@(posedge clk) disable iff (!rst_n)
    gate_pulse |=> !gate_pulse);

  a_r7_gate_clears_lock: assert property (@(posedge clk) disable iff (!rst_n)
    gate_pulse |-> !locked);

  a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !coarse_locked |=> (!locked && !gate_pulse && run_len == '0 && !dir_up));

  a_r10_gate_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    gate_pulse |-> $past(sample_valid));

  a_r10_hold_run: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_pulse && $past(coarse_locked) && $past(rst_n)) |-> ($stable(run_len) && $stable(dir_up)));

  a_r6_lock_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(sample_valid));
endmodule

bind fuzzy_border_gate fuzzy_border_gate_chk #(.MW(MW)) u_chk (.*);

// File: tb/fuzzy_border_gate_tb.sv
module fuzzy_border_gate_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, coarse_locked = 0, sample_valid = 0;
  logic [15:0] sample_code = 0;
  logic [3:0]  persist_k = 4'd3;
  logic [7:0]  lock_len = 8'd4;
  logic        gate_pulse, dir_up, locked;
  logic [15:0] run_len;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [16:0] exp_q[$];

  bit m_ref = 0, m_lock = 0;
  int m_cur = 0, m_cand = 0, m_cc = 0, m_run = 0, m_still = 0;

  fuzzy_border_gate u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    m_ref = 0; m_lock = 0; m_cc = 0; m_run = 0; m_still = 0;
  endtask

  task automatic send(input int c, input string tag);
    int k;
    k = (persist_k == 0) ? 1 : int'(persist_k);
    if (!m_ref) begin
      m_ref = 1; m_cur = c; m_cc = 0; m_run = 1; m_still = 1;
      if (m_still >= lock_len) m_lock = 1;
    end else if (c == m_cur) begin
      m_cc = 0; m_run++; m_still++;
      if (m_still >= lock_len) m_lock = 1;
    end else begin
      if (m_cc != 0 && c == m_cand) m_cc++;
      else begin m_cand = c; m_cc = 1; end
      m_still = 0;
      if (m_cc >= k) begin
        exp_q.push_back({(c > m_cur) ? 1'b1 : 1'b0, 16'(m_run)});
        m_cur = c; m_cc = 0; m_run = k; m_still = k; m_lock = 0;
      end
    end
    @(negedge clk);
    sample_valid = 1; sample_code = 16'(c);
    @(posedge clk); #1;
    check(locked == m_lock, tag, locked, m_lock);
    @(negedge clk);
    sample_valid = 0;
  endtask

  always @(posedge clk) begin
    #1;
    if (gate_pulse) begin
      if (exp_q.size() == 0) check(0, "R3 unexpected gate", 1, 0);
      else begin
        logic [16:0] e;
        e = exp_q.pop_front();
        check(run_len == e[15:0], "R4 run_len", run_len, e[15:0]);
        check(dir_up == e[16], "R5 dir_up", dir_up, e[16]);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(locked == 0 && run_len == 0 && dir_up == 0 && gate_pulse == 0, "R8 reset state", locked, 0);
    coarse_locked = 1;
    @(negedge clk);
    send(100, "R1 reference");
    for (int i = 0; i < 4; i++) send(100, "R6 lock build");
    send(300, "R7 noise keeps lock");
    send(100, "R3 back to run");
    send(100, "R6 run continues");
    for (int i = 0; i < 3; i++) send(101, "R7 border clears lock");
    send(99, "R3 candidate");
    send(99, "R3 candidate");
    for (int i = 0; i < 3; i++) send(98, "R2 candidate restart");
    for (int i = 0; i < 2; i++) send(98, "R6 after border");
    sample_code = 16'hBEEF;
    repeat (3) @(negedge clk);
    check(locked == m_lock, "R10 idle holds lock", locked, m_lock);
    check(run_len == 16'd3, "R10 idle holds run_len", run_len, 3);
    coarse_locked = 0;
    model_clear();
    repeat (2) @(negedge clk);
    check(locked == 0 && run_len == 0 && dir_up == 0, "R8 disable clears", run_len, 0);
    coarse_locked = 1;
    @(negedge clk);
    send(50, "R1 reference after enable");
    for (int i = 0; i < 3; i++) send(50, "R6 relock");
    persist_k = 4'd0;
    send(60, "R9 k zero");
    send(40, "R9 k zero down");
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2 all gates seen", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule